// File: doc/BRIEF.md
# Frame Bank Address Sequencer

This block drives the destination address for a video capture write engine. Software gives it a base address for each of up to eight frame buffers, which are called banks. It also gives a mask that says which banks take part. At every frame end reported by the pixel pipeline, the block moves to the next bank in the ring. It presents that bank's base address to the memory write master, and it publishes the bank index the next frame will land in.

Frame-start and frame-end events set sticky flags in a status register. Software clears them by writing ones. An enable register decides which flags reach the interrupt line. The status index always names the bank being filled next, not the one that just finished. Software finds the completed buffer by stepping back one bank, wrapping around the ring.

The register port is a plain single-cycle strobe interface, with no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. A read returns its data on `reg_rdata` one clock after the edge where `reg_rd` is high. The frame strobes are single-cycle pulses with no handshake, and the block accepts one every cycle.

Top module: `frame_bank_seq`

## Requirements
- R1: After reset the following hold. The bank index is 0 and `irq` is 0. The enable and status registers read 0. The valid register (offset 0x148) reads all ones across NUM_BANKS bits. Every bank address reads 0.
- R2: Each bank n has two 32-bit address registers: the lower word at offset 0x100+8n and the upper word at 0x104+8n. Both read back what was written, except bits [8:0] of the lower word. Those bits always read 0, because banks are 512-byte aligned.
- R3: `bank_addr` equals {upper word, lower word} of the bank selected by `bank_idx`, with bits [8:0] zero.
- R4: A `frame_end` pulse advances `bank_idx` by one in the same clock edge, as long as the index is below the last bank of the ring.
- R5: The last bank of the ring is the highest set bit of the valid mask. A `frame_end` at the last bank returns the index to 0. A mask of 0 leaves only bank 0, so the index stays 0.
- R6: A write to the valid register restarts the index at 0. This holds even when a `frame_end` arrives on the same edge.
- R7: The bank status register (offset 0x14C) shows the next destination index in bits [2:0], with all other bits 0. The bank completed by the last frame equals this index minus one, wrapping to the last bank when the index is 0.
- R8: The status register (offset 0x8) latches `frame_end` in bit 16 and `frame_start` in bit 17. Writing a 1 to a bit clears it, and writing a 0 leaves it alone. A new event wins over a clear that falls on the same edge.
- R9: Bit 17 of the enable register (offset 0x4) enables the frame-end flag, and bit 16 enables the frame-start flag. All other enable bits read 0. `irq` is the OR of every status flag ANDed with its enable.
- R10: A write to an unmapped offset changes nothing. A read of an unmapped offset returns 0. Offsets 0x140 and above lie outside the bank window when NUM_BANKS is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| frame_start | input | 1 | Frame-start pulse from the pixel pipeline |
| frame_end | input | 1 | Frame-end pulse from the pixel pipeline |
| bank_addr | output | 64 | Base address of the current destination bank |
| bank_idx | output | 3 | Index of the bank the next frame goes to |
| irq | output | 1 | Frame interrupt |

## Verification
Two collisions are the hardest situations to reach from the ports. In the first, a write-one-to-clear lands on the same edge as a new frame event. In the second, the valid mask is rewritten while a frame end is advancing the ring. The bench drives both strobes in one cycle, then reads the status register or `bank_idx` in the next cycle.

Beyond the collisions, the bench sweeps every contiguous mask width from one to eight banks, plus an empty mask and one sparse mask. For each mask it runs the ring through more than two full laps. After every step it checks the published index, the output address and the stepped-back completed bank against arithmetic computed in the bench.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_IRQ_EN   = 12'h004;
  localparam logic [REG_AW-1:0] OFS_IRQ_STS  = 12'h008;
  localparam logic [REG_AW-1:0] OFS_BANK_WIN = 12'h100;
  localparam logic [REG_AW-1:0] OFS_VALID    = 12'h148;
  localparam logic [REG_AW-1:0] OFS_BSTAT    = 12'h14C;

  localparam int EN_FEND_BIT   = 17;
  localparam int EN_FSTART_BIT = 16;
  localparam int ST_FEND_BIT   = 16;
  localparam int ST_FSTART_BIT = 17;

  localparam int BANK_STRIDE = 8;
endpackage

// File: rtl/fbs_bank_store.sv
module fbs_bank_store
  import fbs_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int ALIGN_BITS = 9,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic              hit,
  output logic [REG_DW-1:0] rd_word,
  output logic [2*REG_DW-1:0] cur_addr
);
  localparam int SPAN = NUM_BANKS * BANK_STRIDE;

  logic [REG_DW-1:0] lo_q [NUM_BANKS];
  logic [REG_DW-1:0] hi_q [NUM_BANKS];
  logic [31:0]       a32;
  logic [31:0]       off;
  logic [IDX_W-1:0]  sel;
  logic              upper;

  always_comb begin
    a32   = 32'(addr);
    off   = a32 - 32'(OFS_BANK_WIN);
    sel   = off[IDX_W+2:3];
    upper = off[2];
    hit   = (a32 >= 32'(OFS_BANK_WIN)) && (a32 < 32'(OFS_BANK_WIN) + 32'(SPAN)) &&
            (addr[1:0] == 2'b00);
  end

  for (genvar n = 0; n < NUM_BANKS; n++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[n] <= '0;
        hi_q[n] <= '0;
      end else if (wr && hit && sel == IDX_W'(n)) begin
        if (upper) hi_q[n] <= wdata;
        else       lo_q[n] <= {wdata[REG_DW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit) rd_word = upper ? hi_q[sel] : lo_q[sel];
  end

  assign cur_addr = {hi_q[cur_idx], lo_q[cur_idx]};

  // R3: output address only moves when the index moves or a register is written
  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr) && cur_idx == $past(cur_idx)) |-> cur_addr == $past(cur_addr));
endmodule

// File: rtl/fbs_bank_ring.sv
module fbs_bank_ring
  import fbs_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_mask,
  input  logic [NUM_BANKS-1:0] wmask,
  input  logic                 frame_end,
  output logic [NUM_BANKS-1:0] mask,
  output logic [IDX_W-1:0]     idx,
  output logic [IDX_W-1:0]     last
);
  logic [NUM_BANKS-1:0] mask_q;
  logic [IDX_W-1:0]     idx_q;

  always_comb begin
    last = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (mask_q[i]) last = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      idx_q  <= '0;
    end else if (wr_mask) begin
      mask_q <= wmask;
      idx_q  <= '0;
    end else if (frame_end) begin
      idx_q <= (idx_q >= last) ? '0 : idx_q + 1'b1;
    end
  end

  assign mask = mask_q;
  assign idx  = idx_q;

  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !wr_mask && idx_q < last) |=> idx_q == $past(idx_q) + 1'b1);
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !wr_mask && idx_q == last) |=> idx_q == '0);
  a_r5_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= last);
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> idx_q == '0);
endmodule

// File: rtl/fbs_irq_ctrl.sv
module fbs_irq_ctrl
  import fbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sts,
  input  logic [REG_DW-1:0] wdata,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic [REG_DW-1:0] en_word,
  output logic [REG_DW-1:0] sts_word,
  output logic              irq
);
  logic en_fe_q, en_fs_q, st_fe_q, st_fs_q;
  logic clr_fe, clr_fs;

  assign clr_fe = wr_sts && wdata[ST_FEND_BIT];
  assign clr_fs = wr_sts && wdata[ST_FSTART_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_fe_q <= 1'b0;
      en_fs_q <= 1'b0;
      st_fe_q <= 1'b0;
      st_fs_q <= 1'b0;
    end else begin
      if (wr_en) begin
        en_fe_q <= wdata[EN_FEND_BIT];
        en_fs_q <= wdata[EN_FSTART_BIT];
      end
      st_fe_q <= frame_end   | (st_fe_q & ~clr_fe);
      st_fs_q <= frame_start | (st_fs_q & ~clr_fs);
    end
  end

  always_comb begin
    en_word = '0;
    en_word[EN_FEND_BIT]   = en_fe_q;
    en_word[EN_FSTART_BIT] = en_fs_q;
    sts_word = '0;
    sts_word[ST_FEND_BIT]   = st_fe_q;
    sts_word[ST_FSTART_BIT] = st_fs_q;
  end

  assign irq = (st_fe_q & en_fe_q) | (st_fs_q & en_fs_q);

  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> sts_word[ST_FEND_BIT]);
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fe && !frame_end) |=> !sts_word[ST_FEND_BIT]);
  a_r9_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_word == '0) |-> !irq);
endmodule

// File: rtl/frame_bank_seq.sv
module frame_bank_seq
  import fbs_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int ALIGN_BITS = 9,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata,
  input  logic                frame_start,
  input  logic                frame_end,
  output logic [2*REG_DW-1:0] bank_addr,
  output logic [IDX_W-1:0]    bank_idx,
  output logic                irq
);
  logic                 bank_hit;
  logic [REG_DW-1:0]    bank_word, en_word, sts_word, rd_val;
  logic [NUM_BANKS-1:0] mask;
  logic [IDX_W-1:0]     idx, last;
  logic                 wr_mask, wr_en, wr_sts;

  assign wr_mask = reg_wr && reg_addr == OFS_VALID;
  assign wr_en   = reg_wr && reg_addr == OFS_IRQ_EN;
  assign wr_sts  = reg_wr && reg_addr == OFS_IRQ_STS;

  fbs_bank_store #(.NUM_BANKS(NUM_BANKS), .ALIGN_BITS(ALIGN_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cur_idx(idx), .hit(bank_hit), .rd_word(bank_word), .cur_addr(bank_addr));

  fbs_bank_ring #(.NUM_BANKS(NUM_BANKS)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wmask(reg_wdata[NUM_BANKS-1:0]),
    .frame_end(frame_end), .mask(mask), .idx(idx), .last(last));

  fbs_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sts(wr_sts), .wdata(reg_wdata),
    .frame_start(frame_start), .frame_end(frame_end),
    .en_word(en_word), .sts_word(sts_word), .irq(irq));

  always_comb begin
    rd_val = '0;
    if (bank_hit) rd_val = bank_word;
    else begin
      case (reg_addr)
        OFS_IRQ_EN:  rd_val = en_word;
        OFS_IRQ_STS: rd_val = sts_word;
        OFS_VALID:   rd_val = REG_DW'(mask);
        OFS_BSTAT:   rd_val = REG_DW'(idx);
        default:     rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  assign bank_idx = idx;

  // R7: the published index never names a bank beyond the ring
  a_r7_idx_published: assert property (@(posedge clk) disable iff (!rst_n)
    bank_idx <= last);
endmodule

// File: tb/frame_bank_seq_test.sv
module frame_bank_seq_test;
  localparam int CLK_NS = 10;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_start = 1'b0, frame_end = 1'b0;
  logic [63:0] bank_addr;
  logic [2:0]  bank_idx;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] lo_exp [NB];
  logic [31:0] hi_exp [NB];

  always #(CLK_NS/2) clk = ~clk;

  frame_bank_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .frame_end(frame_end), .bank_addr(bank_addr), .bank_idx(bank_idx), .irq(irq));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic fe();
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic fs();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int exp_idx, last, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 idx", 64'(bank_idx), 0);
    chk("R1 irq", 64'(irq), 0);
    rd(12'h004, d); chk("R1 enable", 64'(d), 0);
    rd(12'h008, d); chk("R1 status", 64'(d), 0);
    rd(12'h148, d); chk("R1 valid", 64'(d), 64'hFF);
    rd(12'h14C, d); chk("R1 bstat", 64'(d), 0);
    rd(12'h100, d); chk("R1 bank0 lo", 64'(d), 0);
    chk("R1 bank_addr", bank_addr, 0);

    // R2 program every bank with junk low bits
    for (int n = 0; n < NB; n++) begin
      wr(12'(12'h100 + 8*n), 32'h1000_01FF + 32'(n) * 32'h0001_0000);
      wr(12'(12'h104 + 8*n), 32'hA0 + 32'(n));
      lo_exp[n] = (32'h1000_01FF + 32'(n) * 32'h0001_0000) & ~32'h1FF;
      hi_exp[n] = 32'hA0 + 32'(n);
    end
    for (int n = 0; n < NB; n++) begin
      rd(12'(12'h100 + 8*n), d); chk("R2 lo readback", 64'(d), 64'(lo_exp[n]));
      rd(12'(12'h104 + 8*n), d); chk("R2 hi readback", 64'(d), 64'(hi_exp[n]));
    end

    // R10 unmapped offsets
    wr(12'h144, 32'hDEAD_BEEF);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h102, 32'hFFFF_FFFF);
    rd(12'h144, d); chk("R10 read 0x144", 64'(d), 0);
    rd(12'h010, d); chk("R10 read 0x010", 64'(d), 0);
    rd(12'h102, d); chk("R10 read misaligned", 64'(d), 0);
    rd(12'h100, d); chk("R10 bank0 untouched", 64'(d), 64'(lo_exp[0]));
    chk("R10 bank_addr untouched", bank_addr, {hi_exp[0], lo_exp[0]});

    // R3 R4 R5 R7 sweep over every contiguous ring size
    for (int m = 1; m <= NB; m++) begin
      wr(12'h148, 32'((1 << m) - 1));
      exp_idx = 0;
      chk("R6 restart after mask write", 64'(bank_idx), 0);
      for (int k = 0; k < 2*m + 1; k++) begin
        chk("R3 bank_addr", bank_addr, {hi_exp[exp_idx], lo_exp[exp_idx]});
        prev = exp_idx;
        fe();
        exp_idx = (exp_idx + 1) % m;
        chk("R4/R5 index step", 64'(bank_idx), 64'(exp_idx));
        rd(12'h14C, d);
        chk("R7 bstat", 64'(d), 64'(exp_idx));
        chk("R7 completed bank", 64'((d == 0) ? (m - 1) : (d - 1)), 64'(prev));
      end
    end

    // R5 empty mask keeps bank 0
    wr(12'h148, 32'h0);
    fe(); fe();
    chk("R5 empty mask idx", 64'(bank_idx), 0);
    chk("R5 empty mask addr", bank_addr, {hi_exp[0], lo_exp[0]});

    // R5 sparse mask: last = bit 5
    wr(12'h148, 32'h25);
    last = 5; exp_idx = 0;
    for (int k = 0; k < 14; k++) begin
      fe();
      exp_idx = (exp_idx == last) ? 0 : exp_idx + 1;
      chk("R5 sparse ring", 64'(bank_idx), 64'(exp_idx));
    end

    // R6 mask write collides with frame_end
    wr(12'h148, 32'hFF);
    fe(); fe(); fe();
    chk("R4 idx before collision", 64'(bank_idx), 3);
    frame_end = 1'b1;
    wr(12'h148, 32'hFF);
    frame_end = 1'b0;
    chk("R6 restart wins", 64'(bank_idx), 0);

    // R8 R9 interrupt flags
    wr(12'h008, 32'h0003_0000);
    rd(12'h008, d); chk("R8 cleared", 64'(d), 0);
    fe();
    rd(12'h008, d); chk("R8 frame_end flag", 64'(d), 64'h0001_0000);
    chk("R9 irq masked", 64'(irq), 0);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R9 enable bits", 64'(d), 64'h0003_0000);
    chk("R9 irq on frame_end", 64'(irq), 1);
    wr(12'h008, 32'h0);
    rd(12'h008, d); chk("R8 write zero keeps", 64'(d), 64'h0001_0000);
    wr(12'h008, 32'h0001_0000);
    rd(12'h008, d); chk("R8 w1c", 64'(d), 0);
    chk("R9 irq after clear", 64'(irq), 0);
    fs();
    rd(12'h008, d); chk("R8 frame_start flag", 64'(d), 64'h0002_0000);
    chk("R9 irq on frame_start", 64'(irq), 1);
    wr(12'h008, 32'h0002_0000);
    wr(12'h004, 32'h0002_0000);
    fs();
    chk("R9 start flag not enabled", 64'(irq), 0);
    fe();
    chk("R9 end flag enabled", 64'(irq), 1);
    wr(12'h008, 32'h0003_0000);
    frame_end = 1'b1;
    wr(12'h008, 32'h0001_0000);
    frame_end = 1'b0;
    rd(12'h008, d); chk("R8 event wins over clear", 64'(d), 64'h0001_0000);

    finish_run();
  end
endmodule